// File: doc/BRIEF.md
# Palette Entry Format Converter Loader

This block fills a colour lookup table. After a `start` pulse it accepts raw 32-bit palette words on a valid/ready stream. Each accepted word is turned into an 8-bit red, 8-bit green and 8-bit blue value plus one transparency flag. The result goes out on a palette write port and into an internal entry RAM. The entry RAM has its own index read port, so the pixel path can look up colours.

The pixel depth latched at `start` sets how many entries a load takes. The format code and the grayscale mode pin set how each word is decoded. The block also keeps every raw word. If the format code or the grayscale mode changes after a load has finished, the block decodes the stored words again and rewrites the whole table, with no new traffic on the stream.

Back-pressure rules for the stream:
- `s_ready` is high only while a load is in progress.
- A word is consumed on a clock edge where both `s_valid` and `s_ready` are high.
- `s_valid` low simply stalls the load.
- The source must hold `s_data` stable while `s_valid` is high and `s_ready` is low.

Top module: `pal_loader`

## Requirements
- R1: A load started with `depth_sel` 0 writes 4 entries, 1 writes 16 entries and 2 writes 256 entries. Addresses run 0, 1, 2 and so on in the order the words arrive.
- R2: `start` with `depth_sel` 3 is ignored: `s_ready` stays low, no entry is written and `done` stays low.
- R3: Format code 0 maps bits 15:11 to red, 10:5 to green and 4:0 to blue. Each field sits at the top of its 8-bit channel and the lower bits are zero. The transparency flag is 0.
- R4: Format code 1 decodes the colours as format code 0, and the transparency flag is word bit 24.
- R5: Format code 2 takes red = bits 23:19, green = bits 15:10 and blue = bits 7:3, each top-aligned with zero fill. The transparency flag is bit 24.
- R6: Format code 3 takes red = bits 23:16, green = bits 15:8 and blue = bits 7:0. The transparency flag is bit 24.
- R7: With `gray_en` high, red, green and blue all equal word bits 7:0. The transparency flag follows the format code.
- R8: Each accepted word gives exactly one `pal_we` cycle, on the clock edge after the handshake. `s_ready` is low when no load is running. Cycles with `s_valid` low consume nothing.
- R9: `done` is a single-cycle pulse. It comes in the cycle right after the final `pal_we` of a load or a re-decode, and never together with `pal_we`.
- R10: After a load, a change of `fmt_sel` or `gray_en` re-decodes all stored entries into the new format. It writes them in address order and ends with `done`. `s_ready` stays low throughout.
- R11: `rd_data` gives the entry at `rd_idx` one clock later. Bit 24 is the transparency flag, bits 23:16 are red, bits 15:8 are green and bits 7:0 are blue. `pal_wdata` uses the same layout.
- R12: While reset is held and after it is released, `pal_we`, `done` and `s_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load (accepted only when idle) |
| depth_sel | input | 2 | Pixel depth: 0 = 2-bit, 1 = 4-bit, 2 = 8-bit, 3 = no palette |
| fmt_sel | input | 2 | Source word format code 0..3 |
| gray_en | input | 1 | Grayscale mode |
| s_valid | input | 1 | Raw word valid |
| s_ready | output | 1 | Raw word accepted when high with s_valid |
| s_data | input | 32 | Raw palette word |
| pal_we | output | 1 | Palette write strobe |
| pal_waddr | output | IDX_W | Palette write index |
| pal_wdata | output | 25 | Decoded entry {flag, R, G, B} |
| done | output | 1 | Load or re-decode complete pulse |
| rd_idx | input | IDX_W | Lookup index |
| rd_data | output | 25 | Decoded entry at rd_idx, one cycle later |

## Verification
If the index counter or the end-of-table value is wrong, the symptoms show up at the ports within a few cycles:
- a write address goes out of order;
- `done` arrives after too few or too many `pal_we` strobes;
- `s_ready` stays high or drops early.

A stale format latch shows differently. The wrong colour appears on the very first `pal_wdata` after a load or re-decode starts. A raw-store fault is hidden until a format change, because only then are the stored words decoded a second time. The scoreboard flags that mismatch on the first re-written entry.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic       t;
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } pal_entry_t;

  localparam int ENTRY_W = $bits(pal_entry_t);

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RECONV} pal_state_e;

  localparam logic [1:0] DEPTH_NONE = 2'd3;
endpackage

// File: rtl/pal_conv.sv
module pal_conv
  import pal_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [1:0]        fmt,
  input  logic              gray,
  output pal_entry_t        ent
);
  always_comb begin
    ent.t = (fmt == 2'd0) ? 1'b0 : word[24];
    unique case (fmt)
      2'd0, 2'd1: begin
        ent.r = {word[15:11], 3'b000};
        ent.g = {word[10:5], 2'b00};
        ent.b = {word[4:0], 3'b000};
      end
      2'd2: begin
        ent.r = {word[23:19], 3'b000};
        ent.g = {word[15:10], 2'b00};
        ent.b = {word[7:3], 3'b000};
      end
      default: begin
        ent.r = word[23:16];
        ent.g = word[15:8];
        ent.b = word[7:0];
      end
    endcase
    if (gray) begin
      ent.r = word[7:0];
      ent.g = word[7:0];
      ent.b = word[7:0];
    end
  end
endmodule

// File: rtl/pal_mem.sv
module pal_mem #(
  parameter int W      = 32,
  parameter int AW     = 8,
  parameter bit REG_RD = 1'b0
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  generate
    if (REG_RD) begin : g_sync
      logic [W-1:0] rd_q;
      always_ff @(posedge clk) rd_q <= mem[raddr];
      assign rdata = rd_q;
    end else begin : g_async
      assign rdata = mem[raddr];
    end
  endgenerate
endmodule

// File: rtl/pal_loader.sv
module pal_loader
  import pal_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [1:0]          depth_sel,
  input  logic [1:0]          fmt_sel,
  input  logic                gray_en,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [WORD_W-1:0]   s_data,
  output logic                pal_we,
  output logic [IDX_W-1:0]    pal_waddr,
  output logic [ENTRY_W-1:0]  pal_wdata,
  output logic                done,
  input  logic [IDX_W-1:0]    rd_idx,
  output logic [ENTRY_W-1:0]  rd_data
);
  pal_state_e         state;
  logic [IDX_W-1:0]   cnt, last_q;
  logic [1:0]         cfg_fmt;
  logic               cfg_gray, loaded;
  logic               wlast_q;
  logic               take, step, at_last, cfg_change;
  logic [WORD_W-1:0]  raw_rd, src_word;
  pal_entry_t         conv;

  function automatic logic [IDX_W-1:0] last_of(input logic [1:0] d);
    case (d)
      2'd0:    return IDX_W'(3);
      2'd1:    return IDX_W'(15);
      default: return IDX_W'(255);
    endcase
  endfunction

  assign s_ready    = (state == ST_LOAD);
  assign take       = s_valid && s_ready;
  assign step       = take || (state == ST_RECONV);
  assign at_last    = (cnt == last_q);
  assign src_word   = (state == ST_LOAD) ? s_data : raw_rd;
  assign cfg_change = loaded && ((fmt_sel != cfg_fmt) || (gray_en != cfg_gray));

  pal_conv u_conv (
    .word (src_word),
    .fmt  (cfg_fmt),
    .gray (cfg_gray),
    .ent  (conv)
  );

  pal_mem #(.W(WORD_W), .AW(IDX_W), .REG_RD(1'b0)) u_raw (
    .clk   (clk),
    .we    (take),
    .waddr (cnt),
    .wdata (s_data),
    .raddr (cnt),
    .rdata (raw_rd)
  );

  pal_mem #(.W(ENTRY_W), .AW(IDX_W), .REG_RD(1'b1)) u_ent (
    .clk   (clk),
    .we    (pal_we),
    .waddr (pal_waddr),
    .wdata (pal_wdata),
    .raddr (rd_idx),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      last_q    <= '0;
      cfg_fmt   <= 2'd0;
      cfg_gray  <= 1'b0;
      loaded    <= 1'b0;
      pal_we    <= 1'b0;
      pal_waddr <= '0;
      pal_wdata <= '0;
      wlast_q   <= 1'b0;
      done      <= 1'b0;
    end else begin
      pal_we    <= step;
      pal_waddr <= cnt;
      pal_wdata <= conv;
      wlast_q   <= step && at_last;
      done      <= pal_we && wlast_q;
      unique case (state)
        ST_IDLE: begin
          if (start && (depth_sel != DEPTH_NONE)) begin
            state    <= ST_LOAD;
            cnt      <= '0;
            last_q   <= last_of(depth_sel);
            cfg_fmt  <= fmt_sel;
            cfg_gray <= gray_en;
            loaded   <= 1'b0;
          end else if (cfg_change) begin
            state    <= ST_RECONV;
            cnt      <= '0;
            cfg_fmt  <= fmt_sel;
            cfg_gray <= gray_en;
          end
        end
        ST_LOAD: begin
          if (take) begin
            cnt <= cnt + 1'b1;
            if (at_last) begin
              state  <= ST_IDLE;
              loaded <= 1'b1;
            end
          end
        end
        default: begin
          cnt <= cnt + 1'b1;
          if (at_last) state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/pal_loader_chk.sv
module pal_loader_chk #(
  parameter int IDX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_valid,
  input logic             s_ready,
  input logic             pal_we,
  input logic [IDX_W-1:0] pal_waddr,
  input logic             done
);
  logic [IDX_W-1:0] exp_addr;

  always_ff @(posedge clk) begin
    if (!rst_n)      exp_addr <= '0;
    else if (done)   exp_addr <= '0;
    else if (pal_we) exp_addr <= pal_waddr + 1'b1;
  end

  // R1: writes walk the table in order from index 0
  a_r1_addr_order: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> (pal_waddr == exp_addr));

  // R8: every handshake yields a write on the next edge
  a_r8_write_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> pal_we);

  // R9: done lasts one cycle
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: done comes straight after a write and never with one
  a_r9_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(pal_we) && !pal_we));
endmodule

bind pal_loader pal_loader_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .s_valid   (s_valid),
  .s_ready   (s_ready),
  .pal_we    (pal_we),
  .pal_waddr (pal_waddr),
  .done      (done)
);

// File: tb/sim_pal_loader.sv
`timescale 1ns/1ps
module sim_pal_loader;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  depth_sel = 2'd0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        gray_en = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [31:0] s_data = '0;
  logic        pal_we;
  logic [7:0]  pal_waddr;
  logic [24:0] pal_wdata;
  logic        done;
  logic [7:0]  rd_idx = '0;
  logic [24:0] rd_data;

  always #10 clk = ~clk;

  pal_loader u0 (.*);

  typedef struct packed {
    logic [7:0]  addr;
    logic [24:0] data;
    logic [3:0]  rq;
  } item_t;

  item_t       q[$];
  int          total = 0, bad = 0;
  int          wr_cnt = 0;
  bit          done_seen = 0, prev_we = 0, prev_done = 0;
  logic [31:0] raw [256];

  function automatic logic [24:0] model(input logic [31:0] w, input logic [1:0] f, input logic g);
    logic t;
    logic [7:0] r, gr, b;
    t = (f == 2'd0) ? 1'b0 : w[24];
    if (f == 2'd3)      begin r = w[23:16]; gr = w[15:8]; b = w[7:0]; end
    else if (f == 2'd2) begin r = w[23:19] << 3; gr = w[15:10] << 2; b = w[7:3] << 3; end
    else                begin r = w[15:11] << 3; gr = w[10:5] << 2; b = w[4:0] << 3; end
    if (g) begin r = w[7:0]; gr = w[7:0]; b = w[7:0]; end
    return {t, r, gr, b};
  endfunction

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (pal_we) begin
        wr_cnt++;
        if (q.size() == 0) check(1'b0, "R8 write with nothing expected", {7'd0, pal_wdata}, 32'd0);
        else begin
          item_t it;
          it = q.pop_front();
          check(pal_waddr == it.addr && pal_wdata == it.data,
                $sformatf("R%0d entry %0d", it.rq, it.addr), {pal_waddr, pal_wdata[23:0]},
                {it.addr, it.data[23:0]});
          if (pal_wdata[24] != it.data[24]) check(1'b0, "R4 transparency flag", {31'd0, pal_wdata[24]}, {31'd0, it.data[24]});
        end
      end
      if (done) begin
        done_seen = 1;
        check(prev_we && !pal_we && q.size() == 0 && !prev_done, "R9 done placement",
              {prev_we, pal_we, prev_done}, {1'b1, 1'b0, 1'b0});
      end
      prev_we   = pal_we;
      prev_done = done;
    end
  end

  task automatic wait_done(input bit ready_low);
    int n = 0;
    while (!done_seen && n < 3000) begin
      @(negedge clk);
      if (ready_low && !done_seen) check(!s_ready, "R10 ready low while re-decoding", {31'd0, s_ready}, 32'd0);
      n++;
    end
    check(done_seen, "R9 done reached", {31'd0, done_seen}, 32'd1);
    @(negedge clk);
  endtask

  task automatic do_load(input logic [1:0] d, input logic [1:0] f, input logic g,
                         input int gap, input int seed, input logic [3:0] rq);
    int n;
    n = (d == 2'd0) ? 4 : (d == 2'd1) ? 16 : 256;
    done_seen = 0;
    wr_cnt = 0;
    @(negedge clk);
    depth_sel = d; fmt_sel = f; gray_en = g; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = (32'h9E3779B9 * (i + seed)) ^ (32'h01000000 * (i & 1)) ^ (i << 5);
      raw[i] = w;
      if (gap != 0 && (i % gap) == 1) begin
        s_valid = 1'b0;
        @(negedge clk);
        check(!pal_we || q.size() != 0, "R8 stall consumed nothing", {31'd0, pal_we}, 32'd0);
      end
      s_valid = 1'b1;
      s_data  = w;
      while (!s_ready) @(negedge clk);
      q.push_back('{addr: 8'(i), data: model(w, f, g), rq: rq});
      @(negedge clk);
    end
    s_valid = 1'b0;
    wait_done(1'b0);
    check(wr_cnt == n, "R1 entry count", wr_cnt, n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 during reset
    check(!pal_we && !done && !s_ready, "R12 reset outputs", {pal_we, done, s_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!pal_we && !done && !s_ready, "R12 after reset", {pal_we, done, s_ready}, 0);
    check(!s_ready, "R8 ready low when idle", {31'd0, s_ready}, 0);

    do_load(2'd0, 2'd0, 1'b0, 0, 3, 4'd3);   // R3, R1 four entries
    do_load(2'd1, 2'd1, 1'b0, 3, 11, 4'd4);  // R4 with gaps, R8
    do_load(2'd1, 2'd2, 1'b0, 0, 29, 4'd5);  // R5
    do_load(2'd2, 2'd3, 1'b0, 5, 41, 4'd6);  // R6, R1 256 entries

    // R11 read port
    for (int k = 0; k < 256; k += 37) begin
      rd_idx = 8'(k);
      @(negedge clk);
      check(rd_data == model(raw[k], 2'd3, 1'b0), "R11 read entry", {7'd0, rd_data}, {7'd0, model(raw[k], 2'd3, 1'b0)});
    end

    do_load(2'd0, 2'd3, 1'b1, 0, 53, 4'd7); // R7 grayscale
    do_load(2'd0, 2'd0, 1'b1, 2, 61, 4'd7); // R7 grayscale, flag off

    // R2 depth code 3 ignored
    done_seen = 0; wr_cnt = 0;
    @(negedge clk);
    depth_sel = 2'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(!s_ready, "R2 ready stays low", {31'd0, s_ready}, 0);
    end
    check(wr_cnt == 0 && !done_seen, "R2 no writes no done", wr_cnt, 0);

    // R10 re-decode on format change
    do_load(2'd1, 2'd1, 1'b0, 0, 77, 4'd10);
    done_seen = 0; wr_cnt = 0;
    for (int i = 0; i < 16; i++) q.push_back('{addr: 8'(i), data: model(raw[i], 2'd2, 1'b0), rq: 4'd10});
    fmt_sel = 2'd2;
    wait_done(1'b1);
    check(wr_cnt == 16, "R10 re-decode count", wr_cnt, 16);
    // R10 re-decode on grayscale change
    done_seen = 0; wr_cnt = 0;
    for (int i = 0; i < 16; i++) q.push_back('{addr: 8'(i), data: model(raw[i], 2'd2, 1'b1), rq: 4'd10});
    gray_en = 1'b1;
    wait_done(1'b1);
    check(wr_cnt == 16, "R10 gray re-decode count", wr_cnt, 16);
    rd_idx = 8'd9;
    @(negedge clk);
    check(rd_data == model(raw[9], 2'd2, 1'b1), "R11 read after re-decode", {7'd0, rd_data}, {7'd0, model(raw[9], 2'd2, 1'b1)});

    repeat (4) @(negedge clk);
    check(q.size() == 0, "R8 scoreboard drained", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule